// File: doc/BRIEF.md
# Program-Counter Breakpoint Comparator Unit

This unit watches the address of each retiring instruction and asks the core to halt when that address hits one of a small set of programmable comparator slots. A slot fires only when its own conditions are met. It must be enabled. The retiring address must equal its match address. The instruction-valid strobe must be high. If the slot has a register condition, a monitored core value must equal the slot's compare value. Finally, the slot's qualified-match count must have reached its threshold.

Debug software sets up the slots through a single write port with address, data and write strobe. A slot can be made temporary, so that it disarms itself when it fires. Each slot also belongs to a group, and one command enables or disables every slot in a group at once. The unit's output is a registered one-cycle halt request together with the index of the slot that caused it.

Top module: `hw_bkpt_unit`

## Requirements
- R1: A slot fires in a cycle when it is enabled, `pc_valid` is 1, `pc` equals its match address, its condition (R3) holds and its threshold (R4) is met. `halt_o` is 1 in the cycle after any slot fires and 0 otherwise.
- R2: A cycle with `pc_valid` at 0 never fires a slot and never advances a hit counter.
- R3: When a slot's condition enable is set, a match counts as a hit only if `mon_val` equals the slot's compare value. When the condition enable is clear, `mon_val` is ignored.
- R4: A slot with threshold N fires on its Nth hit and on every later hit, and not on hits 1 to N-1. A threshold of 0 behaves as 1. The hit counter stops at N.
- R5: A temporary slot clears its own enable at the clock edge that registers its firing, so it does not fire again until it is re-enabled.
- R6: A write with `cfg_addr[5]`=1 is a group command. It sets the enable of every slot whose group equals `cfg_wdata[GRP_W-1:0]` to `cfg_wdata[8]`. It does not change those slots' counters.
- R7: When several slots fire in the same cycle, a single halt is raised and `halt_slot_o` reports the lowest-numbered of them.
- R8: Any slot write (R10) clears that slot's hit counter. In the same cycle, a write to a slot takes precedence over that slot's temporary self-clear.
- R9: After reset, all slots are disabled with a zero threshold and zero counters, and `halt_o` is 0.
- R10: A write with `cfg_addr[5]`=0 targets slot `cfg_addr[4:2]`, or does nothing if that index is not below NUM_SLOTS. The field is chosen by `cfg_addr[1:0]`:
  - 0 is control: bit0 enable, bit1 temporary, bit2 condition enable, bits[GRP_W+3:4] group.
  - 1 is the match address.
  - 2 is the compare value.
  - 3 is the threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Configuration address (R10, R6) |
| cfg_wdata | input | 32 | Configuration write data |
| pc_valid | input | 1 | Retiring instruction valid |
| pc | input | ADDR_W | Retiring instruction address |
| mon_val | input | DATA_W | Monitored register value |
| halt_o | output | 1 | Halt request, one cycle per firing cycle |
| halt_slot_o | output | IDX_W | Index of the slot that fired, valid with halt_o |

## Verification
The assertions check four things on every cycle. A halt follows exactly the cycles in which some slot fired. The reported index is a firing slot with no lower firing slot. No slot fires while it is disabled or while `pc_valid` is low. A temporary slot that fires without a competing write is disarmed on the next cycle. The bench scenarios are what show the rest: the Nth-hit threshold and its saturation, the register condition, counter clearing on a rewrite, and group commands. They do this by comparing each halt against a cycle-by-cycle reference model under directed sequences and random traffic.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  localparam int CFG_AW = 6;
  localparam int CFG_DW = 32;

  typedef enum logic [1:0] {
    FLD_CTRL = 2'd0,
    FLD_ADDR = 2'd1,
    FLD_CVAL = 2'd2,
    FLD_THR  = 2'd3
  } bkpt_field_e;

  // threshold of zero acts as one
  function automatic int unsigned thr_eff(input int unsigned thr);
    return (thr == 0) ? 1 : thr;
  endfunction

  // a hit fires once this hit brings the count up to the threshold
  function automatic logic hit_due(input int unsigned cnt, input int unsigned thr);
    return (cnt + 1) >= thr_eff(thr);
  endfunction

  // count advances on a hit and saturates at the threshold
  function automatic int unsigned next_count(input int unsigned cnt, input int unsigned thr);
    return (cnt >= thr_eff(thr)) ? cnt : cnt + 1;
  endfunction
endpackage

// File: rtl/bkpt_slot.sv
module bkpt_slot #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 8,
  parameter int GRP_W  = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_sel,
  input  logic [1:0]                wr_field,
  input  logic [bkpt_pkg::CFG_DW-1:0] wr_data,
  input  logic                      grp_we,
  input  logic [GRP_W-1:0]          grp_id,
  input  logic                      grp_val,
  input  logic                      pc_valid,
  input  logic [ADDR_W-1:0]         pc,
  input  logic [DATA_W-1:0]         mon_val,
  output logic                      fire_o,
  output logic                      en_o,
  output logic                      os_o
);
  import bkpt_pkg::*;

  logic              en_q, os_q, cond_q;
  logic [GRP_W-1:0]  grp_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] cval_q;
  logic [CNT_W-1:0]  thr_q, cnt_q;
  logic              hit;

  assign hit    = en_q && pc_valid && (pc == addr_q) && (!cond_q || (mon_val == cval_q));
  assign fire_o = hit && hit_due(int'(cnt_q), int'(thr_q));
  assign en_o   = en_q;
  assign os_o   = os_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      os_q   <= 1'b0;
      cond_q <= 1'b0;
      grp_q  <= '0;
      addr_q <= '0;
      cval_q <= '0;
      thr_q  <= '0;
      cnt_q  <= '0;
    end else begin
      if (hit) cnt_q <= CNT_W'(next_count(int'(cnt_q), int'(thr_q)));
      if (fire_o && os_q) en_q <= 1'b0;
      if (grp_we && (grp_id == grp_q)) en_q <= grp_val;
      if (wr_sel) begin
        cnt_q <= '0;
        case (bkpt_field_e'(wr_field))
          FLD_CTRL: begin
            en_q   <= wr_data[0];
            os_q   <= wr_data[1];
            cond_q <= wr_data[2];
            grp_q  <= wr_data[GRP_W+3:4];
          end
          FLD_ADDR: addr_q <= wr_data[ADDR_W-1:0];
          FLD_CVAL: cval_q <= wr_data[DATA_W-1:0];
          default:  thr_q  <= wr_data[CNT_W-1:0];
        endcase
      end
    end
  end
endmodule

// File: rtl/bkpt_prio.sv
module bkpt_prio #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]     req,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx_o = IDX_W'(i);
    end
  end
  assign any_o = |req;
endmodule

// File: rtl/hw_bkpt_unit.sv
module hw_bkpt_unit #(
  parameter int NUM_SLOTS = 4,
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 8,
  parameter int GRP_W     = 2,
  localparam int IDX_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_we,
  input  logic [bkpt_pkg::CFG_AW-1:0] cfg_addr,
  input  logic [bkpt_pkg::CFG_DW-1:0] cfg_wdata,
  input  logic                        pc_valid,
  input  logic [ADDR_W-1:0]           pc,
  input  logic [DATA_W-1:0]           mon_val,
  output logic                        halt_o,
  output logic [IDX_W-1:0]            halt_slot_o
);
  logic                 grp_we;
  logic [NUM_SLOTS-1:0] slot_wr, slot_fire, slot_en, slot_os;
  logic                 fire_any;
  logic [IDX_W-1:0]     fire_idx;

  assign grp_we = cfg_we && cfg_addr[5];

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    assign slot_wr[i] = cfg_we && !cfg_addr[5] && (cfg_addr[4:2] == 3'(i));
    bkpt_slot #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .GRP_W(GRP_W)
    ) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_sel   (slot_wr[i]),
      .wr_field (cfg_addr[1:0]),
      .wr_data  (cfg_wdata),
      .grp_we   (grp_we),
      .grp_id   (cfg_wdata[GRP_W-1:0]),
      .grp_val  (cfg_wdata[8]),
      .pc_valid (pc_valid),
      .pc       (pc),
      .mon_val  (mon_val),
      .fire_o   (slot_fire[i]),
      .en_o     (slot_en[i]),
      .os_o     (slot_os[i])
    );
  end

  bkpt_prio #(.N(NUM_SLOTS), .IDX_W(IDX_W)) u_prio (
    .req   (slot_fire),
    .any_o (fire_any),
    .idx_o (fire_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_o      <= 1'b0;
      halt_slot_o <= '0;
    end else begin
      halt_o <= fire_any;
      if (fire_any) halt_slot_o <= fire_idx;
    end
  end
endmodule

// File: rtl/bkpt_unit_chk.sv
module bkpt_unit_chk #(
  parameter int NUM_SLOTS = 4,
  parameter int IDX_W     = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 pc_valid,
  input logic                 grp_we,
  input logic                 halt_o,
  input logic [IDX_W-1:0]     halt_slot_o,
  input logic [NUM_SLOTS-1:0] slot_fire,
  input logic [NUM_SLOTS-1:0] slot_en,
  input logic [NUM_SLOTS-1:0] slot_os,
  input logic [NUM_SLOTS-1:0] slot_wr
);
  logic [NUM_SLOTS-1:0] fire_q;
  logic [NUM_SLOTS-1:0] lower_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fire_q <= '0;
    else        fire_q <= slot_fire;
  end

  assign lower_mask = (NUM_SLOTS'(1) << halt_slot_o) - NUM_SLOTS'(1);

  // R1
  halt_tracks_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_o == (|fire_q));
  // R1
  halt_slot_fired_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_o |-> fire_q[halt_slot_o]);
  // R7
  lowest_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_o |-> ((fire_q & lower_mask) == '0));
  // R2
  fire_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|slot_fire) |-> pc_valid);
  // R1
  fire_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_fire & ~slot_en) == '0);

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_os
    // R5
    oneshot_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_fire[i] && slot_os[i] && !slot_wr[i] && !grp_we) |=> !slot_en[i]);
  end
endmodule

bind hw_bkpt_unit bkpt_unit_chk #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pc_valid    (pc_valid),
  .grp_we      (grp_we),
  .halt_o      (halt_o),
  .halt_slot_o (halt_slot_o),
  .slot_fire   (slot_fire),
  .slot_en     (slot_en),
  .slot_os     (slot_os),
  .slot_wr     (slot_wr)
);

// File: tb/tb_hw_bkpt_unit.sv
`timescale 1ns/1ps
module tb_hw_bkpt_unit;
  localparam int NS = 4;
  localparam int IW = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        pc_valid = 1'b0;
  logic [31:0] pc = '0;
  logic [31:0] mon_val = '0;
  logic        halt_o;
  logic [IW-1:0] halt_slot_o;

  int checks = 0;
  int failures = 0;

  // reference model state
  bit m_en[NS], m_os[NS], m_ce[NS];
  int unsigned m_grp[NS], m_addr[NS], m_cval[NS], m_thr[NS], m_cnt[NS];
  bit exp_halt = 0;
  int exp_slot = 0;

  always #2.5 clk = ~clk;

  hw_bkpt_unit #(.NUM_SLOTS(NS)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pc_valid(pc_valid), .pc(pc), .mon_val(mon_val),
    .halt_o(halt_o), .halt_slot_o(halt_slot_o)
  );

  function automatic bit m_reached(int unsigned cnt, int unsigned thr);
    int unsigned need = (thr > 0) ? thr - 1 : 0;
    return cnt >= need;
  endfunction

  function automatic int unsigned m_bump(int unsigned cnt, int unsigned thr);
    int unsigned cap = (thr > 1) ? thr : 1;
    return (cnt + 1 > cap) ? cap : cnt + 1;
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(bit we, logic [5:0] a, logic [31:0] d, bit v,
                      logic [31:0] p, logic [31:0] m, string tag);
    bit hit[NS];
    bit fire[NS];
    bit any = 0;
    int idx = 0;
    cfg_we = we; cfg_addr = a; cfg_wdata = d;
    pc_valid = v; pc = p; mon_val = m;
    for (int i = 0; i < NS; i++) begin
      hit[i]  = m_en[i] && v && (p == m_addr[i]) && (!m_ce[i] || m == m_cval[i]);
      fire[i] = hit[i] && m_reached(m_cnt[i], m_thr[i]);
    end
    for (int i = NS - 1; i >= 0; i--) if (fire[i]) begin any = 1; idx = i; end
    @(posedge clk);
    for (int i = 0; i < NS; i++) begin
      if (hit[i]) m_cnt[i] = m_bump(m_cnt[i], m_thr[i]);
      if (fire[i] && m_os[i]) m_en[i] = 0;
      if (we && a[5] && (d[1:0] == m_grp[i][1:0])) m_en[i] = d[8];
      if (we && !a[5] && (a[4:2] == 3'(i))) begin
        m_cnt[i] = 0;
        case (a[1:0])
          2'd0: begin m_en[i] = d[0]; m_os[i] = d[1]; m_ce[i] = d[2]; m_grp[i] = d[5:4]; end
          2'd1: m_addr[i] = d;
          2'd2: m_cval[i] = d;
          default: m_thr[i] = d[7:0];
        endcase
      end
    end
    exp_halt = any;
    if (any) exp_slot = idx;
    @(negedge clk);
    cfg_we = 0;
    check(halt_o === exp_halt, tag, "halt_o", int'(halt_o), int'(exp_halt));
    if (exp_halt) check(halt_slot_o === IW'(exp_slot), tag, "halt_slot_o",
                        int'(halt_slot_o), exp_slot);
  endtask

  task automatic wr(int slot, int fld, logic [31:0] d, string tag);
    step(1, {1'b0, 3'(slot), 2'(fld)}, d, 0, 0, 0, tag);
  endtask

  task automatic run(logic [31:0] p, logic [31:0] m, string tag);
    step(0, 6'd0, 32'd0, 1, p, m, tag);
  endtask

  function automatic logic [31:0] ctrl(bit en, bit os, bit ce, int g);
    return {26'd0, 2'(g), 1'b0, ce, os, en};
  endfunction

  initial begin : wdog
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [31:0] addr_pool[8];
    for (int i = 0; i < 8; i++) addr_pool[i] = 32'h100 * (i + 1);
    for (int i = 0; i < NS; i++) begin
      m_en[i] = 0; m_os[i] = 0; m_ce[i] = 0;
      m_grp[i] = 0; m_addr[i] = 0; m_cval[i] = 0; m_thr[i] = 0; m_cnt[i] = 0;
    end
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(halt_o === 1'b0, "R9", "halt_o after reset", int'(halt_o), 0);
    run(32'h0, 0, "R9 disabled after reset");

    // R1 basic match on slot 0
    wr(0, 1, 32'h100, "R10");
    wr(0, 0, ctrl(1, 0, 0, 0), "R10");
    run(32'h100, 0, "R1 basic");
    run(32'h104, 0, "R1 no match");
    // R2 stalled cycle
    step(0, 0, 0, 0, 32'h100, 0, "R2 stall");

    // R3 register condition on slot 1
    wr(1, 1, 32'h200, "R10");
    wr(1, 2, 32'h55, "R10");
    wr(1, 0, ctrl(1, 0, 1, 2), "R10");
    run(32'h200, 32'h54, "R3 cond mismatch");
    run(32'h200, 32'h55, "R3 cond match");

    // R4 threshold 3 on slot 2, with stalls in between (R2)
    wr(2, 1, 32'h300, "R10");
    wr(2, 3, 32'd3, "R10");
    wr(2, 0, ctrl(1, 0, 0, 3), "R10");
    run(32'h300, 0, "R4 hit1");
    step(0, 0, 0, 0, 32'h300, 0, "R2 stall no count");
    run(32'h300, 0, "R4 hit2");
    run(32'h300, 0, "R4 hit3 fires");
    run(32'h300, 0, "R4 saturated fires");

    // R8 rewrite clears counter
    wr(2, 3, 32'd3, "R8 rewrite");
    run(32'h300, 0, "R8 hit1 after clear");
    run(32'h300, 0, "R8 hit2 after clear");
    run(32'h300, 0, "R8 hit3 fires");

    // R5 temporary slot 3
    wr(3, 1, 32'h400, "R10");
    wr(3, 0, ctrl(1, 1, 0, 3), "R10");
    run(32'h400, 0, "R5 first fires");
    run(32'h400, 0, "R5 disarmed");
    // R8 write wins over temporary self-clear in the same cycle
    wr(3, 0, ctrl(1, 1, 0, 3), "R10");
    step(1, {1'b0, 3'd3, 2'd0}, ctrl(1, 1, 0, 3), 1, 32'h400, 0, "R8 write vs clear");
    run(32'h400, 0, "R8 still armed");

    // R7 priority: slot 1 also on 0x100 without condition
    wr(1, 1, 32'h100, "R10");
    wr(1, 0, ctrl(1, 0, 0, 1), "R10");
    wr(0, 0, ctrl(1, 0, 0, 1), "R10");
    run(32'h100, 0, "R7 lowest wins");

    // R6 group commands on group 1
    step(1, 6'b100000, 32'h001, 0, 0, 0, "R6 disable grp1");
    run(32'h100, 0, "R6 group disabled");
    step(1, 6'b100000, 32'h101, 0, 0, 0, "R6 enable grp1");
    run(32'h100, 0, "R6 group enabled");
    step(1, 6'b100000, 32'h000, 0, 0, 0, "R6 disable grp0");
    run(32'h100, 0, "R6 other group untouched");

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      bit we = ($urandom % 6) == 0;
      logic [5:0] a = 6'($urandom);
      logic [31:0] d;
      int f = int'(a[1:0]);
      if (f == 1) d = addr_pool[$urandom % 8];
      else if (f == 2) d = 32'($urandom % 2);
      else if (f == 3) d = 32'($urandom % 4);
      else d = $urandom;
      step(we, a, d, ($urandom % 4) != 0, addr_pool[$urandom % 8],
           32'($urandom % 2), "R1 R7 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule